// File: doc/BRIEF.md
# Coin Credit Accumulator

This block is the acceptance core of a vending machine. It counts the value of coins dropped into the slot, 10 units for a dime and 25 units for a quarter. Once the credit reaches 35 units or more it raises a flag that stays high. Each coin sensor delivers a single-cycle, already-clean pulse. The surrounding logic watches the flag and clears the block with a synchronous reset after the vend.

The credit is held as one of five buckets in a three-bit register: 0, 10, 20, the merged bucket for 25 or 30, and 35-or-more. Those two middle credits share one code because every coin lifts either of them past 35. The next-state bits come from minimised sum-of-products equations rather than a case table. The saturated bucket is always stored as one fixed code.

Top module: `coin_credit_fsm`

## Requirements
- R1: With `rst` high at a rising clock edge, `state` becomes 000 and `paid` becomes 0 at that edge. This holds even when a coin pulse is high in the same cycle.
- R2: Below 35 units, an edge with neither `dime` nor `quarter` high leaves `state` unchanged.
- R3: A dime moves `state` from 000 to 001, from 001 to 010, and from 010 to 011, taking one code per edge.
- R4: A dime while `state` is 011 (credit 25 or 30) moves `state` to 100.
- R5: A quarter while `state` is 000 moves `state` to 011.
- R6: A quarter while `state` is 001, 010 or 011 moves `state` to 100.
- R7: Once `state` is 100, it stays 100 under any coin inputs, including both pulses together, until reset.
- R8: `paid` is high exactly when `state` is 100. The codes 101, 110 and 111 never appear.
- R9: For any stream with at most one coin per cycle, `state` matches the running credit saturated at 35: 0→000, 10→001, 20→010, 25 or 30→011, 35 or more→100. Below 35, dime and quarter must not be high together; that input is unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dime | input | 1 | One-cycle pulse: a 10-unit coin was accepted |
| quarter | input | 1 | One-cycle pulse: a 25-unit coin was accepted |
| state | output | 3 | Credit bucket code |
| paid | output | 1 | Credit has reached 35 or more |

## Verification
Reset and a coin pulse can land on the same edge. The bench drives `rst` together with a dime while credit is partway up, and also just after the saturated state is reached. It then expects 000 with `paid` low, because reset must win. Dime and quarter can also coincide, but only in the saturated state, where the bench drives both and expects 100 to hold. Every stream of up to five single coins is swept from reset and compared cycle by cycle with an arithmetic sum that saturates at 35.

// File: rtl/coin_credit_fsm.sv
module coin_credit_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       dime,
  input  logic       quarter,
  output logic [2:0] state,
  output logic       paid
);

  localparam logic [2:0] C_ZERO   = 3'b000;
  localparam logic [2:0] C_TEN    = 3'b001;
  localparam logic [2:0] C_TWENTY = 3'b010;
  localparam logic [2:0] C_MID    = 3'b011;
  localparam logic [2:0] C_PAID   = 3'b100;

  logic q2, q1, q0;
  logic d2, d1, d0;
  logic [2:0] nxt;

  assign {q2, q1, q0} = state;

  // minimised excitation equations; the Q2=1 column is folded to one code
  assign d2 = q2 | (quarter & (q1 | q0)) | (dime & q1 & q0);
  assign d1 = (quarter & ~q0) | q1 | (dime & q0);
  assign d0 = (quarter & ~q0) | (q0 & ~dime) | (dime & ~q0);

  assign nxt = d2 ? C_PAID : {1'b0, d1, d0};

  always_ff @(posedge clk) begin
    if (rst) state <= C_ZERO;
    else     state <= nxt;
  end

  assign paid = state[2];

  p_reset_r1: assert property (@(posedge clk) rst |=> (state == C_ZERO && !paid));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!state[2] && !dime && !quarter) |=> $stable(state));

  p_dime_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state == C_TWENTY && dime && !quarter) |=> state == C_MID);

  p_dime_top_r4: assert property (@(posedge clk) disable iff (rst)
    (state == C_MID && dime) |=> state == C_PAID);

  p_quarter_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (state == C_ZERO && quarter && !dime) |=> state == C_MID);

  p_quarter_up_r6: assert property (@(posedge clk) disable iff (rst)
    (state == C_TEN && quarter) |=> state == C_PAID);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    state[2] |=> state == C_PAID);

  p_legal_code_r8: assert property (@(posedge clk) disable iff (rst)
    state[2] |-> state[1:0] == 2'b00);

  // input contract: one coin per cycle while credit is below 35 (R9)
  p_one_coin_r9: assert property (@(posedge clk) disable iff (rst)
    !state[2] |-> !(dime && quarter));

endmodule

// File: tb/tb_coin_credit_fsm.sv
`timescale 1ns/100ps
module tb_coin_credit_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dime = 1'b0;
  logic quarter = 1'b0;
  logic [2:0] state;
  logic paid;
  int compared = 0;
  int mismatched = 0;
  int credit = 0;

  coin_credit_fsm dut (.clk(clk), .rst(rst), .dime(dime), .quarter(quarter),
                       .state(state), .paid(paid));

  always #2.5 clk = ~clk;

  function automatic logic [2:0] code_of(input int c);
    if (c >= 35) return 3'b100;
    if (c >= 25) return 3'b011;
    if (c >= 20) return 3'b010;
    if (c >= 10) return 3'b001;
    return 3'b000;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    compared++;
    if (state !== exp) begin
      mismatched++;
      $display("FAIL %s state actual=%b expected=%b", req, state, exp);
    end
    compared++;
    if (paid !== exp[2]) begin
      mismatched++;
      $display("FAIL R8 paid actual=%b expected=%b", paid, exp[2]);
    end
  endtask

  task automatic drive(input logic d, input logic q, input logic r);
    dime = d; quarter = q; rst = r;
    @(negedge clk);
    dime = 1'b0; quarter = 1'b0; rst = 1'b0;
  endtask

  task automatic do_reset();
    drive(1'b0, 1'b0, 1'b1);
    credit = 0;
    check("R1", 3'b000);
  endtask

  task automatic coin(input int kind);
    string tag;
    if (credit >= 35) tag = "R7";
    else if (kind == 0) tag = "R2";
    else if (kind == 1) tag = (credit >= 25) ? "R4" : "R3";
    else tag = (credit == 0) ? "R5" : "R6";
    drive(kind == 1, kind == 2, 1'b0);
    if (kind == 1) credit += 10;
    if (kind == 2) credit += 25;
    if (credit > 35) credit = 35;
    check(tag, code_of(credit));
    compared++;
    if (state !== code_of(credit)) begin
      mismatched++;
      $display("FAIL R9 credit=%0d actual=%b expected=%b", credit, state, code_of(credit));
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // exhaustive sweep of five-step streams over {none, dime, quarter}
    for (int s = 0; s < 243; s++) begin
      int v;
      v = s;
      do_reset();
      for (int k = 0; k < 5; k++) begin
        coin(v % 3);
        v = v / 3;
      end
    end
    // R7: both coins together once saturated
    do_reset();
    coin(2); coin(1);
    drive(1'b1, 1'b1, 1'b0);
    check("R7", 3'b100);
    drive(1'b1, 1'b1, 1'b0);
    check("R7", 3'b100);
    // R1: reset coinciding with a dime, mid credit and when paid
    do_reset();
    coin(1); coin(1);
    drive(1'b1, 1'b0, 1'b1);
    credit = 0;
    check("R1", 3'b000);
    coin(2); coin(2);
    drive(1'b1, 1'b0, 1'b1);
    credit = 0;
    check("R1", 3'b000);
    // R2: long idle hold at each sub-35 bucket
    for (int b = 0; b < 4; b++) begin
      do_reset();
      for (int i = 0; i < b; i++) coin(1);
      for (int i = 0; i < 4; i++) coin(0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule